// File: doc/BRIEF.md
# LED Source Selector with Status Pulse Stretching

This block drives eight board LEDs from one of two sources. The first source is an 8-bit LED register that software writes over a zero-wait-state APB slave port. The second source is a group of eight processor status lines. Each status line passes through its own pulse stretcher, so an event that lasts one clock still shows as a visible flash. A single mode bit, held in a separate control register, picks the source.

The stretchers run at all times, whichever source is selected. A flash that starts while software owns the LEDs therefore still shows if the mode changes to status before the flash has expired. Writes to the LED register update it in either mode, and a read always returns the stored value.

Top module: `led_status_mux`

## Requirements
- R1: While `presetn` is low, `ledOut` is 0x00. After reset, the LED register reads 0x00 and the mode register reads 0.
- R2: A write to offset 0x0C stores `pwdata[7:0]` in the LED register. A read of offset 0x0C returns that value in bits 7:0, with bits 31:8 as zero.
- R3: A write to offset 0x14 stores `pwdata[0]` as the mode bit. A read of offset 0x14 returns the mode bit in bit 0, with bits 31:1 as zero.
- R4: With mode 0, `ledOut` equals the LED register. A value of 1 in a bit lights that LED.
- R5: With mode 1, `ledOut` shows the stretched status lines in this order:
  - bit 7: `sleeping`
  - bit 6: `sleepDeep`
  - bit 5: `halted`
  - bit 4: `lockup`
  - bit 3: `sysResetReq`
  - bit 2: `txEvent`
  - bit 1: `wakeup`
  - bit 0: `dbgRestarted`
- R6: A status line that is high for exactly one sampling edge makes its stretched bit high from that edge for exactly STRETCH_CYCLES clock cycles.
- R7: Every edge on which a status line is high reloads its stretcher. A line held high keeps its bit high, and the bit drops STRETCH_CYCLES cycles after the last edge on which the line was high.
- R8: The stretchers run while mode is 0, with no effect on `ledOut`. A flash still in progress shows as soon as mode becomes 1.
- R9: `pready` is always 1 and `pslverr` is always 0.
- R10: The following have no effect:
  - writes to any other offset;
  - a setup phase that has no access phase.
  Reads of any other offset return zero.
- R11: A write to the LED register while mode is 1 leaves `ledOut` unchanged. The written value appears on `ledOut` once mode returns to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Clock |
| presetn | input | 1 | Active-low synchronous reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write (1) or read (0) |
| paddr | input | 12 | APB byte offset |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data, valid while `psel` is high for a read |
| pready | output | 1 | Always 1 |
| pslverr | output | 1 | Always 0 |
| sleeping | input | 1 | Status: core sleeping |
| sleepDeep | input | 1 | Status: deep sleep |
| halted | input | 1 | Status: halted in debug |
| lockup | input | 1 | Status: lockup |
| sysResetReq | input | 1 | Status: system reset request |
| txEvent | input | 1 | Status: transmit event |
| wakeup | input | 1 | Status: wakeup |
| dbgRestarted | input | 1 | Status: debug restarted |
| ledOut | output | 8 | LED drive, 1 lights the LED |

## Verification
The assertions assume that APB transfers are well formed:
- an access phase always follows a setup phase with the same address and direction;
- `paddr` and `pwrite` hold steady across the two phases.

The assertions also assume that status lines change only between clock edges. The bench drives every input on the falling edge and uses only two-phase transfers, apart from one deliberate setup phase with no access phase. It spaces its status pulses so that each stretch can be seen expiring. STRETCH_CYCLES is set small so that each window completes within the run.

// File: rtl/led_pkg.sv
package led_pkg;
  typedef struct packed {
    logic ledWr;
    logic modeWr;
    logic ledRd;
    logic modeRd;
  } ledStrobe_t;
endpackage

// File: rtl/led_apb_ctrl.sv
module led_apb_ctrl
  import led_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] LED_OFS = 'h00C,
  parameter logic [ADDR_W-1:0] MODE_OFS = 'h014
)(
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  output ledStrobe_t        strb
);
  logic hitLed;
  logic hitMode;
  logic wrAccess;
  logic rdSelect;

  assign hitLed   = (paddr == LED_OFS);
  assign hitMode  = (paddr == MODE_OFS);
  assign wrAccess = psel & penable & pwrite;
  assign rdSelect = psel & ~pwrite;

  always_comb begin
    strb.ledWr  = wrAccess & hitLed;
    strb.modeWr = wrAccess & hitMode;
    strb.ledRd  = rdSelect & hitLed;
    strb.modeRd = rdSelect & hitMode;
  end
endmodule

// File: rtl/led_stretch.sv
module led_stretch #(
  parameter int LED_N = 8,
  parameter int STRETCH_CYCLES = 1 << 20
)(
  input  logic             pclk,
  input  logic             presetn,
  input  logic [LED_N-1:0] statusVec,
  output logic [LED_N-1:0] stretchVec
);
  localparam int CNT_W = $clog2(STRETCH_CYCLES + 1);
  localparam logic [CNT_W-1:0] RELOAD = CNT_W'(STRETCH_CYCLES);

  for (genvar i = 0; i < LED_N; i++) begin : g_bit
    logic [CNT_W-1:0] cnt;
    always_ff @(posedge pclk) begin
      if (!presetn) begin
        cnt <= '0;
      end else if (statusVec[i]) begin
        cnt <= RELOAD;
      end else if (cnt != '0) begin
        cnt <= cnt - CNT_W'(1);
      end
    end
    assign stretchVec[i] = (cnt != '0);
  end
endmodule

// File: rtl/led_reg_path.sv
module led_reg_path
  import led_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LED_N = 8
)(
  input  logic              pclk,
  input  logic              presetn,
  input  ledStrobe_t        strb,
  input  logic [LED_N-1:0]  wrData,
  input  logic [LED_N-1:0]  stretchVec,
  output logic [LED_N-1:0]  ledOut,
  output logic              modeSel,
  output logic [DATA_W-1:0] prdata
);
  logic [LED_N-1:0] ledQ;
  logic             modeQ;

  always_ff @(posedge pclk) begin
    if (!presetn) begin
      ledQ  <= '0;
      modeQ <= 1'b0;
    end else begin
      if (strb.ledWr)  ledQ  <= wrData;
      if (strb.modeWr) modeQ <= wrData[0];
    end
  end

  always_comb begin
    prdata = '0;
    if (strb.ledRd)       prdata = DATA_W'(ledQ);
    else if (strb.modeRd) prdata = DATA_W'(modeQ);
  end

  assign modeSel = modeQ;
  assign ledOut  = modeQ ? stretchVec : ledQ;
endmodule

// File: rtl/led_status_mux.sv
module led_status_mux
  import led_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int STRETCH_CYCLES = 1 << 20,
  parameter logic [ADDR_W-1:0] LED_OFS = 'h00C,
  parameter logic [ADDR_W-1:0] MODE_OFS = 'h014
)(
  input  logic              pclk,
  input  logic              presetn,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DATA_W-1:0] pwdata,
  output logic [DATA_W-1:0] prdata,
  output logic              pready,
  output logic              pslverr,
  input  logic              sleeping,
  input  logic              sleepDeep,
  input  logic              halted,
  input  logic              lockup,
  input  logic              sysResetReq,
  input  logic              txEvent,
  input  logic              wakeup,
  input  logic              dbgRestarted,
  output logic [7:0]        ledOut
);
  localparam int LED_N = 8;

  ledStrobe_t       strb;
  logic [LED_N-1:0] statusVec;
  logic [LED_N-1:0] stretchVec;
  logic             modeSel;
  logic             unusedWdata;

  assign statusVec = {sleeping, sleepDeep, halted, lockup,
                      sysResetReq, txEvent, wakeup, dbgRestarted};
  assign unusedWdata = ^pwdata[DATA_W-1:LED_N];
  assign pready  = 1'b1;
  assign pslverr = 1'b0;

  led_apb_ctrl #(.ADDR_W(ADDR_W), .LED_OFS(LED_OFS), .MODE_OFS(MODE_OFS)) u_ctrl (
    .psel(psel), .penable(penable), .pwrite(pwrite), .paddr(paddr), .strb(strb)
  );

  led_stretch #(.LED_N(LED_N), .STRETCH_CYCLES(STRETCH_CYCLES)) u_stretch (
    .pclk(pclk), .presetn(presetn), .statusVec(statusVec), .stretchVec(stretchVec)
  );

  led_reg_path #(.DATA_W(DATA_W), .LED_N(LED_N)) u_path (
    .pclk(pclk), .presetn(presetn), .strb(strb), .wrData(pwdata[LED_N-1:0]),
    .stretchVec(stretchVec), .ledOut(ledOut), .modeSel(modeSel), .prdata(prdata)
  );
endmodule

// File: rtl/led_status_mux_chk.sv
module led_status_mux_chk #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] LED_OFS = 'h00C
)(
  input logic              pclk,
  input logic              presetn,
  input logic              psel,
  input logic              penable,
  input logic              pwrite,
  input logic [ADDR_W-1:0] paddr,
  input logic [DATA_W-1:0] prdata,
  input logic              pready,
  input logic              pslverr,
  input logic              modeSel,
  input logic [7:0]        statusVec,
  input logic [7:0]        stretchVec,
  input logic [7:0]        ledOut
);
  logic wrLed;
  assign wrLed = psel & penable & pwrite & (paddr == LED_OFS);

  a_r1_reset_dark: assert property (@(posedge pclk) !presetn |=> ledOut == 8'h00);

  a_r9_no_wait: assert property (@(posedge pclk) disable iff (!presetn)
    pready && !pslverr);

  a_r2_upper_zero: assert property (@(posedge pclk) disable iff (!presetn)
    psel |-> prdata[DATA_W-1:8] == '0);

  a_r7_reload: assert property (@(posedge pclk) disable iff (!presetn)
    (|statusVec) |=> ((stretchVec & $past(statusVec)) == $past(statusVec)));

  a_r6_no_early_drop: assert property (@(posedge pclk) disable iff (!presetn)
    (($past(stretchVec) & ~stretchVec & $past(statusVec)) == 8'h00));

  a_r4_led_steady: assert property (@(posedge pclk) disable iff (!presetn)
    (!modeSel && !$past(modeSel) && !$past(wrLed)) |-> $stable(ledOut));
endmodule

bind led_status_mux led_status_mux_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LED_OFS(LED_OFS)
) u_chk (
  .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable), .pwrite(pwrite),
  .paddr(paddr), .prdata(prdata), .pready(pready), .pslverr(pslverr),
  .modeSel(modeSel), .statusVec(statusVec), .stretchVec(stretchVec), .ledOut(ledOut)
);

// File: tb/sim_led_status_mux.sv
module sim_led_status_mux;
  localparam int S = 6;

  logic        pclk = 1'b0;
  logic        presetn = 1'b0;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [11:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic        pready, pslverr;
  logic [7:0]  st = 8'h00;
  logic [7:0]  ledOut;

  int checks = 0;
  int fails = 0;
  int mCnt [8];
  logic [7:0] mLed = 8'h00;
  logic       mMode = 1'b0;

  always #4 pclk = ~pclk;

  led_status_mux #(.STRETCH_CYCLES(S)) u0 (
    .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready), .pslverr(pslverr),
    .sleeping(st[7]), .sleepDeep(st[6]), .halted(st[5]), .lockup(st[4]),
    .sysResetReq(st[3]), .txEvent(st[2]), .wakeup(st[1]), .dbgRestarted(st[0]),
    .ledOut(ledOut)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, got, exp, $time);
    end
  endtask

  function automatic logic [7:0] modelLeds();
    logic [7:0] s;
    for (int i = 0; i < 8; i++) s[i] = (mCnt[i] > 0);
    return mMode ? s : mLed;
  endfunction

  // Behavioural reference, updated on each rising edge
  always @(posedge pclk) begin
    if (!presetn) begin
      mLed = 8'h00;
      mMode = 1'b0;
      for (int i = 0; i < 8; i++) mCnt[i] = 0;
    end else begin
      if (psel && penable && pwrite) begin
        if (paddr == 12'h00C) mLed = pwdata[7:0];
        else if (paddr == 12'h014) mMode = pwdata[0];
      end
      for (int i = 0; i < 8; i++) begin
        if (st[i]) mCnt[i] = S;
        else if (mCnt[i] > 0) mCnt[i] = mCnt[i] - 1;
      end
    end
  end

  always @(negedge pclk) begin
    if (presetn) begin
      check(mMode ? "R5 per-cycle status" : "R4 per-cycle register", {24'h0, ledOut}, {24'h0, modelLeds()});
      check("R9 handshake", {30'h0, pready, pslverr}, 32'h2);
    end
  end

  task automatic apbWrite(input logic [11:0] a, input logic [31:0] d);
    @(negedge pclk);
    psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d; penable = 1'b0;
    @(negedge pclk);
    penable = 1'b1;
    @(negedge pclk);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic apbRead(input logic [11:0] a, input logic [31:0] exp, input string tag);
    @(negedge pclk);
    psel = 1'b1; pwrite = 1'b0; paddr = a; penable = 1'b0;
    @(negedge pclk);
    penable = 1'b1;
    #1 check(tag, prdata, exp);
    @(negedge pclk);
    psel = 1'b0; penable = 1'b0;
  endtask

  task automatic pulse(input int bitIdx);
    @(negedge pclk);
    st[bitIdx] = 1'b1;
    @(negedge pclk);
    st[bitIdx] = 1'b0;
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge pclk);
    checks++;
    fails++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    finishRun();
  end

  initial begin
    int highs;
    repeat (3) @(negedge pclk);
    check("R1 ledOut in reset", {24'h0, ledOut}, 32'h0);
    presetn = 1'b1;
    apbRead(12'h00C, 32'h0, "R1 LED reg after reset");
    apbRead(12'h014, 32'h0, "R1 mode reg after reset");

    apbWrite(12'h00C, 32'h0000_00A5);
    apbRead(12'h00C, 32'h0000_00A5, "R2 LED readback");
    check("R4 ledOut follows register", {24'h0, ledOut}, 32'hA5);
    apbWrite(12'h00C, 32'hFFFF_FF3C);
    apbRead(12'h00C, 32'h0000_003C, "R2 upper bits read zero");
    check("R4 ledOut second value", {24'h0, ledOut}, 32'h3C);

    apbWrite(12'h010, 32'h0000_0000);
    apbWrite(12'h018, 32'h0000_0001);
    @(negedge pclk);
    psel = 1'b1; pwrite = 1'b1; paddr = 12'h00C; pwdata = 32'h0; penable = 1'b0;
    @(negedge pclk);
    psel = 1'b0; pwrite = 1'b0;
    apbRead(12'h00C, 32'h0000_003C, "R10 stray writes ignored");
    apbRead(12'h014, 32'h0, "R10 mode untouched by stray writes");
    apbRead(12'h010, 32'h0, "R10 unmapped read zero");
    check("R10 ledOut unchanged", {24'h0, ledOut}, 32'h3C);

    pulse(4);
    check("R8 stretch hidden in register mode", {24'h0, ledOut}, 32'h3C);
    apbWrite(12'h014, 32'hFFFF_FFFF);
    check("R8 running flash shows after switch", {31'h0, ledOut[4]}, 32'h1);
    apbRead(12'h014, 32'h1, "R3 mode readback");

    repeat (2 * S) @(negedge pclk);
    check("R5 quiet status dark", {24'h0, ledOut}, 32'h0);

    pulse(0);
    highs = 0;
    for (int k = 0; k < 3 * S; k++) begin
      if (ledOut[0]) highs++;
      @(negedge pclk);
    end
    check("R6 single pulse stretch length", highs, S);

    for (int i = 0; i < 8; i++) begin
      pulse(i);
      check("R5 status bit mapping", {24'h0, ledOut}, 32'(8'h01 << i));
      repeat (S + 2) @(negedge pclk);
    end

    @(negedge pclk);
    st[6] = 1'b1;
    repeat (3 * S) @(negedge pclk);
    check("R7 held line stays lit", {31'h0, ledOut[6]}, 32'h1);
    st[6] = 1'b0;
    highs = 0;
    for (int k = 0; k < 3 * S; k++) begin
      if (ledOut[6]) highs++;
      @(negedge pclk);
    end
    check("R7 release tail length", highs, S);

    apbWrite(12'h00C, 32'h0000_000F);
    check("R11 LED write hidden in status mode", {24'h0, ledOut}, 32'h0);
    apbWrite(12'h014, 32'h0);
    check("R11 LED value shown after return", {24'h0, ledOut}, 32'h0F);
    apbRead(12'h00C, 32'h0000_000F, "R11 LED readback");

    repeat (4) @(negedge pclk);
    finishRun();
  end
endmodule